// File: doc/BRIEF.md
# Converter Test Word Generator

This block sits on the output data path of a multi-channel analog-to-digital converter. When a test mode is active, it places a deterministic 16-bit word on the output in place of the converted sample. With the mode set to off, the converter sample passes through unchanged. The output is registered. It updates only on clock edges where the sample enable is high, so the block follows the converter's own sample rate.

The available patterns fall into four groups:
- fixed levels;
- two-phase patterns that swap between two words on every sample;
- two pseudo-random sequences from linear feedback shift registers, a short one of order 9 and a long one of order 23, each with its own reseed input;
- a pattern built from two user-supplied words.

The user pattern plays in one of four ways: one word repeated, two words alternating, one word once, or two words once. Serialisation of the output word and register access lie outside this block.

Top module: `adc_test_word_gen`

## Requirements
- R1: While `rst_n` is low, and until the first enabled sample after it is released, `dout` reads 0x0000. Both sequence generators hold their all-ones seed.
- R2: `dout` changes only on a clock edge with `smp_en` high. On that edge it takes the word selected by `mode`. With `mode` 0000 or any code from 1101 to 1111, that word is `din` as sampled on the same edge.
- R3: Fixed words: 0001 gives 0x8000, 0010 gives 0xFFFF, 0011 gives 0x0000, 1010 gives 0x00FF and 1011 gives 0x0001.
- R4: Two-phase words, first phase then second: 0100 gives 0x5555 then 0xAAAA, 0111 gives 0x0000 then 0xFFFF, 1001 gives 0xAAAA then 0x5555, and 1100 gives 0x3333 then 0xCCCC. The phase changes on every enabled sample. The first enabled sample at which `{mode, usr_mode}` differs from its value at the previous enabled sample takes the first phase. After reset, the previous value counts as all zeros.
- R5: Mode 0101 outputs the long sequence, with new bit = s[22] XOR s[17] (x^23+x^18+1) and state shifted left with the new bit entering at bit 0. Each enabled sample produces 16 new bits, the first in bit 15. Both generators advance on every enabled sample, whatever the mode.
- R6: Mode 0110 outputs the short sequence under the same rules, with new bit = s[8] XOR s[4] (x^9+x^5+1).
- R7: `pn_long_rst` reseeds only the long generator and `pn_short_rst` reseeds only the short one. A reseed raised on an enabled sample makes that sample's word the first word from the all-ones seed.
- R8: Mode 1000 with `usr_mode` 00 outputs `usr_word_a` on every sample. With `usr_mode` 01 it alternates `usr_word_a` and `usr_word_b`, starting with `usr_word_a` under the phase rule of R4.
- R9: Mode 1000 with `usr_mode` 10 outputs `usr_word_a` once. With 11 it outputs `usr_word_a` then `usr_word_b`. Afterwards it outputs 0x0000 until `{mode, usr_mode}` changes at an enabled sample.
- R10: On edges with `smp_en` low, `dout` and the pattern phase are unchanged, and the generators advance only through a reseed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_en | input | 1 | Sample enable; one output word per enabled edge |
| mode | input | 4 | Test mode select |
| usr_mode | input | 2 | User pattern playback: 00 single, 01 alternate, 10 single once, 11 alternate once |
| usr_word_a | input | 16 | First user word |
| usr_word_b | input | 16 | Second user word |
| pn_long_rst | input | 1 | Reseed the order-23 generator |
| pn_short_rst | input | 1 | Reseed the order-9 generator |
| din | input | 16 | Converter sample |
| dout | output | 16 | Output word |

## Verification
A wrong phase bit shows up one enabled sample after a mode change, as the second word of a two-phase pattern arriving first, or as a user word that repeats. A stuck one-shot counter shows up as a user word where zero should follow, within three samples. A wrong tap or shift order in a generator changes the very first word after a reseed, so every reseed followed by a sequence mode exposes it on the next enabled edge. Free-running advance across other modes means that a generator which stalls outside its own mode shows up at the next sample in that mode.

// File: rtl/adc_tpg_pkg.sv
package adc_tpg_pkg;

  typedef enum logic [3:0] {
    TM_OFF      = 4'd0,
    TM_MID      = 4'd1,
    TM_PFS      = 4'd2,
    TM_NFS      = 4'd3,
    TM_CHECKER  = 4'd4,
    TM_PN_LONG  = 4'd5,
    TM_PN_SHORT = 4'd6,
    TM_WORD_TGL = 4'd7,
    TM_USER     = 4'd8,
    TM_BIT_TGL  = 4'd9,
    TM_SYNC     = 4'd10,
    TM_ONE_LSB  = 4'd11,
    TM_MIXED    = 4'd12
  } tmode_e;

  typedef enum logic [1:0] {
    UP_SINGLE   = 2'd0,
    UP_ALT      = 2'd1,
    UP_SINGLE_1 = 2'd2,
    UP_ALT_1    = 2'd3
  } umode_e;

  localparam int MODE_W = 4;
  localparam int UMODE_W = 2;
  localparam int CFG_W = MODE_W + UMODE_W;
  localparam int CNT_W = 2;

  localparam int LONG_ORDER  = 23;
  localparam int LONG_TAP    = 18;
  localparam int SHORT_ORDER = 9;
  localparam int SHORT_TAP   = 5;

endpackage

// File: rtl/adc_tpg_rst_sync.sv
module adc_tpg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/adc_tpg_prbs.sv
module adc_tpg_prbs #(
  parameter int ORDER = 9,
  parameter int TAP   = 5,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_en,
  input  logic         seed_req,
  output logic [W-1:0] word
);
  logic [ORDER-1:0] st_q;
  logic [ORDER-1:0] src;
  logic [ORDER-1:0] st_d;
  logic             fb;

  // Unrolled W-step Fibonacci shift; first bit produced lands in the MSB.
  always_comb begin
    src  = seed_req ? {ORDER{1'b1}} : st_q;
    st_d = src;
    word = '0;
    fb   = 1'b0;
    for (int i = 0; i < W; i++) begin
      fb           = st_d[ORDER-1] ^ st_d[TAP-1];
      word[W-1-i]  = fb;
      st_d         = {st_d[ORDER-2:0], fb};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        st_q <= {ORDER{1'b1}};
    else if (adv_en)   st_q <= st_d;
    else if (seed_req) st_q <= {ORDER{1'b1}};
  end
endmodule

// File: rtl/adc_tpg_seq.sv
module adc_tpg_seq
  import adc_tpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_en,
  input  logic [CFG_W-1:0] cfg,
  output logic             phase,
  output logic [CNT_W-1:0] count
);
  logic [CFG_W-1:0] cfg_q;
  logic             phase_q;
  logic [CNT_W-1:0] count_q;
  logic             cfg_chg;
  logic [CNT_W-1:0] count_d;

  always_comb begin
    cfg_chg = (cfg != cfg_q);
    phase   = cfg_chg ? 1'b0 : phase_q;
    count   = cfg_chg ? '0 : count_q;
    count_d = (&count) ? count : count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      phase_q <= 1'b0;
      count_q <= '0;
    end else if (smp_en) begin
      cfg_q   <= cfg;
      phase_q <= ~phase;
      count_q <= count_d;
    end
  end
endmodule

// File: rtl/adc_test_word_gen.sv
module adc_test_word_gen
  import adc_tpg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_en,
  input  logic [3:0]   mode,
  input  logic [1:0]   usr_mode,
  input  logic [W-1:0] usr_word_a,
  input  logic [W-1:0] usr_word_b,
  input  logic         pn_long_rst,
  input  logic         pn_short_rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam logic [W-1:0] WORD_MID   = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] WORD_ONES  = {W{1'b1}};
  localparam logic [W-1:0] WORD_ZERO  = {W{1'b0}};
  localparam logic [W-1:0] WORD_55    = {(W/2){2'b01}};
  localparam logic [W-1:0] WORD_33    = {(W/4){4'b0011}};
  localparam logic [W-1:0] WORD_SYNC  = {{(W/2){1'b0}}, {(W/2){1'b1}}};
  localparam logic [W-1:0] WORD_LSB   = {{(W-1){1'b0}}, 1'b1};

  logic             rst_sync_n;
  logic             phase;
  logic [CNT_W-1:0] count;
  logic [W-1:0]     pn_long_w;
  logic [W-1:0]     pn_short_w;
  logic [W-1:0]     dout_d;
  logic [W-1:0]     dout_q;
  logic [W-1:0]     user_w;

  adc_tpg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  adc_tpg_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .smp_en (smp_en),
    .cfg    ({mode, usr_mode}),
    .phase  (phase),
    .count  (count)
  );

  adc_tpg_prbs #(.ORDER(LONG_ORDER), .TAP(LONG_TAP), .W(W)) u_pn_long (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .adv_en   (smp_en),
    .seed_req (pn_long_rst),
    .word     (pn_long_w)
  );

  adc_tpg_prbs #(.ORDER(SHORT_ORDER), .TAP(SHORT_TAP), .W(W)) u_pn_short (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .adv_en   (smp_en),
    .seed_req (pn_short_rst),
    .word     (pn_short_w)
  );

  always_comb begin
    case (umode_e'(usr_mode))
      UP_SINGLE:   user_w = usr_word_a;
      UP_ALT:      user_w = phase ? usr_word_b : usr_word_a;
      UP_SINGLE_1: user_w = (count == 2'd0) ? usr_word_a : WORD_ZERO;
      default:     user_w = (count == 2'd0) ? usr_word_a :
                            (count == 2'd1) ? usr_word_b : WORD_ZERO;
    endcase
  end

  always_comb begin
    case (mode)
      TM_MID:      dout_d = WORD_MID;
      TM_PFS:      dout_d = WORD_ONES;
      TM_NFS:      dout_d = WORD_ZERO;
      TM_CHECKER:  dout_d = phase ? ~WORD_55 : WORD_55;
      TM_PN_LONG:  dout_d = pn_long_w;
      TM_PN_SHORT: dout_d = pn_short_w;
      TM_WORD_TGL: dout_d = phase ? WORD_ONES : WORD_ZERO;
      TM_USER:     dout_d = user_w;
      TM_BIT_TGL:  dout_d = phase ? WORD_55 : ~WORD_55;
      TM_SYNC:     dout_d = WORD_SYNC;
      TM_ONE_LSB:  dout_d = WORD_LSB;
      TM_MIXED:    dout_d = phase ? ~WORD_33 : WORD_33;
      default:     dout_d = din;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  dout_q <= '0;
    else if (smp_en)  dout_q <= dout_d;
  end

  assign dout = dout_q;
endmodule

// File: rtl/adc_tpg_chk.sv
module adc_tpg_chk (
  input logic        clk,
  input logic        rst_sn,
  input logic        smp_en,
  input logic [3:0]  mode,
  input logic [1:0]  usr_mode,
  input logic [15:0] usr_word_a,
  input logic [15:0] din,
  input logic [15:0] dout
);
  p_pass_off_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (smp_en && (mode == 4'd0 || mode >= 4'd13)) |=> (dout == $past(din)));

  p_pos_full_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (smp_en && mode == 4'd2) |=> (dout == 16'hFFFF));

  p_checker_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    (smp_en && mode == 4'd4) |=> (dout == 16'h5555 || dout == 16'hAAAA));

  p_user_single_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (smp_en && mode == 4'd8 && usr_mode == 2'd0) |=> (dout == $past(usr_word_a)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    !smp_en |=> $stable(dout));
endmodule

bind adc_test_word_gen adc_tpg_chk u_chk (
  .clk        (clk),
  .rst_sn     (rst_sync_n),
  .smp_en     (smp_en),
  .mode       (mode),
  .usr_mode   (usr_mode),
  .usr_word_a (usr_word_a),
  .din        (din),
  .dout       (dout)
);

// File: tb/adc_test_word_gen_tb.sv
`timescale 1ns/1ps
module adc_test_word_gen_tb;
  logic        clk;
  logic        rst_n;
  logic        smp_en;
  logic [3:0]  mode;
  logic [1:0]  usr_mode;
  logic [15:0] usr_word_a, usr_word_b, din;
  logic        pn_long_rst, pn_short_rst;
  logic [15:0] dout;

  int n_tests, n_fail;
  bit finished;

  // reference model state
  logic [5:0]  m_cfg;
  logic        m_ph;
  int          m_cnt;
  logic [22:0] m_pl, m_ps;
  logic [15:0] m_exp;

  adc_test_word_gen u_dut (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .mode(mode), .usr_mode(usr_mode),
    .usr_word_a(usr_word_a), .usr_word_b(usr_word_b), .pn_long_rst(pn_long_rst),
    .pn_short_rst(pn_short_rst), .din(din), .dout(dout)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] pn_word(input logic [22:0] s_in, input int n, input int tap,
                                          output logic [22:0] s_out);
    logic [22:0] s;
    logic        b;
    logic [15:0] w;
    s = s_in;
    w = '0;
    for (int i = 0; i < 16; i++) begin
      b = s[n-1] ^ s[tap-1];
      w[15-i] = b;
      s = ((s << 1) | {22'd0, b}) & ((23'd1 << n) - 23'd1);
    end
    s_out = s;
    return w;
  endfunction

  function automatic string tag_of(input logic en, input logic [3:0] md, input logic [1:0] um);
    if (!en) return "R10";
    case (md)
      4'd1, 4'd2, 4'd3, 4'd10, 4'd11: return "R3";
      4'd4, 4'd7, 4'd9, 4'd12:        return "R4";
      4'd5:                           return "R5";
      4'd6:                           return "R6";
      4'd8:                           return um[1] ? "R9" : "R8";
      default:                        return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: dout=%h expected=%h (mode=%0d umode=%0d)", tag, act, exp, mode, usr_mode);
    end
  endtask

  task automatic model_reset();
    m_cfg = '0; m_ph = 1'b0; m_cnt = 0;
    m_pl = 23'h7FFFFF; m_ps = 23'h1FF; m_exp = '0;
  endtask

  // update the model with the inputs seen at this edge
  task automatic model_edge();
    logic        chg, ph;
    int          cnt;
    logic [15:0] wl, ws, uw;
    logic [22:0] srcl, srcs;
    srcl = pn_long_rst ? 23'h7FFFFF : m_pl;
    srcs = pn_short_rst ? 23'h1FF : m_ps;
    if (smp_en) begin
      chg = ({mode, usr_mode} != m_cfg);
      ph  = chg ? 1'b0 : m_ph;
      cnt = chg ? 0 : m_cnt;
      wl = pn_word(srcl, 23, 18, m_pl);
      ws = pn_word(srcs, 9, 5, m_ps);
      case (usr_mode)
        2'd0: uw = usr_word_a;
        2'd1: uw = ph ? usr_word_b : usr_word_a;
        2'd2: uw = (cnt == 0) ? usr_word_a : 16'h0000;
        default: uw = (cnt == 0) ? usr_word_a : (cnt == 1) ? usr_word_b : 16'h0000;
      endcase
      case (mode)
        4'd1:  m_exp = 16'h8000;
        4'd2:  m_exp = 16'hFFFF;
        4'd3:  m_exp = 16'h0000;
        4'd4:  m_exp = ph ? 16'hAAAA : 16'h5555;
        4'd5:  m_exp = wl;
        4'd6:  m_exp = ws;
        4'd7:  m_exp = ph ? 16'hFFFF : 16'h0000;
        4'd8:  m_exp = uw;
        4'd9:  m_exp = ph ? 16'h5555 : 16'hAAAA;
        4'd10: m_exp = 16'h00FF;
        4'd11: m_exp = 16'h0001;
        4'd12: m_exp = ph ? 16'hCCCC : 16'h3333;
        default: m_exp = din;
      endcase
      m_cfg = {mode, usr_mode};
      m_ph  = ~ph;
      m_cnt = (cnt < 3) ? cnt + 1 : 3;
    end else begin
      m_pl = srcl;
      m_ps = srcs;
    end
  endtask

  // inputs are already driven (at a falling edge); run one clock and check
  task automatic cycle();
    string t;
    t = tag_of(smp_en, mode, usr_mode);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(t, dout, m_exp);
  endtask

  task automatic drive(input logic en, input logic [3:0] md, input logic [1:0] um);
    smp_en = en; mode = md; usr_mode = um;
    din = 16'($urandom);
    pn_long_rst = 1'b0; pn_short_rst = 1'b0;
  endtask

  task automatic run(input logic [3:0] md, input logic [1:0] um, input int n);
    for (int i = 0; i < n; i++) begin
      drive(1'b1, md, um);
      cycle();
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] hold_v;
    logic [15:0] seed_l;
    logic [22:0] dummy;
    n_tests = 0; n_fail = 0; finished = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; smp_en = 1'b0; mode = 4'd0; usr_mode = 2'd0;
    usr_word_a = 16'h1234; usr_word_b = 16'hBEEF; din = 16'h0;
    pn_long_rst = 1'b0; pn_short_rst = 1'b0;
    model_reset();
    repeat (4) @(negedge clk);
    check("R1", dout, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", dout, 16'h0000);

    // R5: first long word after reset comes from the seed
    seed_l = pn_word(23'h7FFFFF, 23, 18, dummy);
    drive(1'b1, 4'd5, 2'd0);
    cycle();
    check("R5", dout, seed_l);

    // R2: pass-through and unused codes
    run(4'd0, 2'd0, 3);
    run(4'd14, 2'd0, 2);
    run(4'd15, 2'd0, 2);
    // R3 fixed levels
    run(4'd1, 2'd0, 2); run(4'd2, 2'd0, 2); run(4'd3, 2'd0, 2);
    run(4'd10, 2'd0, 2); run(4'd11, 2'd0, 2);
    // R4 two-phase, first sample takes first phase
    drive(1'b1, 4'd4, 2'd0); cycle(); check("R4", dout, 16'h5555);
    run(4'd4, 2'd0, 3);
    run(4'd7, 2'd0, 3); run(4'd9, 2'd0, 3); run(4'd12, 2'd0, 3);

    // R10: no enable, dout holds while din and mode move
    hold_v = dout;
    for (int i = 0; i < 5; i++) begin
      drive(1'b0, 4'(i), 2'd1);
      cycle();
      check("R10", dout, hold_v);
    end

    // R7: reseed long on a sample gives the seed word; short reseed leaves long alone
    drive(1'b1, 4'd5, 2'd0); pn_long_rst = 1'b1; cycle();
    check("R7", dout, seed_l);
    run(4'd5, 2'd0, 2);
    drive(1'b1, 4'd5, 2'd0); pn_short_rst = 1'b1; cycle();
    run(4'd6, 2'd0, 3);
    drive(1'b0, 4'd6, 2'd0); pn_short_rst = 1'b1; cycle();
    drive(1'b1, 4'd6, 2'd0); cycle();
    check("R7", dout, pn_word(23'h1FF, 9, 5, dummy));

    // R8 / R9 user patterns
    usr_word_a = 16'hC3A5; usr_word_b = 16'h0F0F;
    run(4'd8, 2'd0, 3);
    run(4'd8, 2'd1, 4);
    run(4'd8, 2'd2, 4);
    check("R9", dout, 16'h0000);
    run(4'd8, 2'd3, 5);
    check("R9", dout, 16'h0000);
    run(4'd8, 2'd2, 1);
    check("R9", dout, 16'hC3A5);

    // constrained random
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 15) == 0) begin
        mode = 4'($urandom_range(0, 15));
        usr_mode = 2'($urandom);
      end
      if ($urandom_range(0, 63) == 0) begin
        usr_word_a = 16'($urandom); usr_word_b = 16'($urandom);
      end
      smp_en = ($urandom_range(0, 3) != 0);
      din = 16'($urandom);
      pn_long_rst = ($urandom_range(0, 49) == 0);
      pn_short_rst = ($urandom_range(0, 49) == 0);
      cycle();
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule